// File: doc/BRIEF.md
# Flash Status and Busy Sequencer

This block is the control core of a serial page flash that sits between the command decoder and the array. It accepts launch requests for the eight self-timed array operations, each with a page address. It keeps the part busy for a cycle count set per operation and reports completion. When a compare finishes, it latches whether the page matched the buffer.

It decides which requests may start. A request that arrives while another array operation runs is dropped. So is a request that would alter a protected page. A buffer read or write is allowed when the part is idle, and also while an erase is in progress. Status reads are always served.

It also supplies the status byte one bit per serial shift. The bits come most significant first, and the byte repeats for as long as chip select stays low. Every bit is taken from the live state, so a poller sees the ready bit change in the middle of a stream.

Top module: `flash_status_seq`

## Requirements
- R1: The status byte is {ready, mismatch flag, 4'b0011, 2'b00}. Bit 7 is 1 when idle and 0 when busy. Bit 6 is 0 after a matching compare and 1 after a mismatching one.
- R2: While `cs_n` is high, the serial bit index is 7. Each `shift_en` cycle with `cs_n` low steps the index down by one, and the step after bit 0 returns to bit 7. `status_bit` always shows the bit of the current status byte at the current index.
- R3: The `launch_op` encoding is 0 transfer, 1 compare, 2 program with erase, 3 program without erase, 4 page erase, 5 block erase, 6 program through buffer, 7 auto rewrite. An accepted launch pulses `op_accept` for one cycle. From the next cycle, `busy_n` is low for exactly the operation's count: CYC_XFER for codes 0 and 1, CYC_ERASE_PROG for codes 2, 6 and 7, CYC_PROG for code 3, CYC_PAGE_ERASE for code 4, and CYC_BLOCK_ERASE for code 5.
- R4: A launch that arrives while `busy_n` is low is dropped. It pulses `op_reject` for one cycle in the next cycle and leaves the running operation's timing unchanged.
- R5: A buffer request pulses `buf_grant` when the part is idle or is running code 4 or 5. Otherwise it pulses `buf_deny`. Either response appears in the next cycle.
- R6: With `wp_n` low, a launch of codes 2 to 7 to a page whose top address bit is 0 (pages 0 to 255 by default) is rejected as in R4. Codes 0 and 1, and any launch to the upper half of the array, are not affected.
- R7: When a compare ends, `cmp_mismatch` is latched into status bit 6. No other operation changes that bit.
- R8: `op_done` pulses for one cycle in the same cycle that `busy_n` returns high.
- R9: `rst_n` low aborts any running operation. It drives `busy_n` high, clears the mismatch flag and the pulse outputs, and returns the serial index to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and abort |
| launch_valid | input | 1 | Array operation launch request |
| launch_op | input | 3 | Operation code (see R3) |
| launch_page | input | PAGE_W | Target page address |
| wp_n | input | 1 | Active-low write protect for the lower half of the array |
| cmp_mismatch | input | 1 | Compare outcome from the array side, held during a compare |
| buf_req | input | 1 | Buffer read or write request |
| cs_n | input | 1 | Serial chip select, active low |
| shift_en | input | 1 | One serial bit shift this cycle |
| busy_n | output | 1 | Active-low busy |
| op_accept | output | 1 | Launch accepted pulse |
| op_reject | output | 1 | Launch dropped pulse |
| op_done | output | 1 | Operation finished pulse |
| buf_grant | output | 1 | Buffer access granted pulse |
| buf_deny | output | 1 | Buffer access denied pulse |
| status_bit | output | 1 | Current serial status bit |

## Verification
Every operation code is launched with write protect both low and high, to pages in both halves of the array. This separates the protection decision by code from the decision by address. Launches and buffer requests arrive during transfers, during erases and during programs, which exposes any mix-up in the group rules. The status stream is clocked across busy-to-ready edges and through chip-select breaks that fall in the middle of a byte, which shows whether the index wraps and restarts correctly and whether bits are taken live. Compares with both outcomes, and a reset in the middle of an operation, show when the flag is latched and what the abort clears.

// File: rtl/fss_pkg.sv
package fss_pkg;

  typedef enum logic [2:0] {
    OP_XFER      = 3'd0,
    OP_CMP       = 3'd1,
    OP_PROG_ER   = 3'd2,
    OP_PROG_NE   = 3'd3,
    OP_PG_ERASE  = 3'd4,
    OP_BLK_ERASE = 3'd5,
    OP_PROG_BUF  = 3'd6,
    OP_REWRITE   = 3'd7
  } op_e;

  localparam logic [3:0] DENSITY_CODE = 4'b0011;

  // Operations that write or erase array pages.
  function automatic logic op_alters_array(op_e op);
    return !(op == OP_XFER || op == OP_CMP);
  endfunction

  // Operations that leave the buffer free for host access.
  function automatic logic op_frees_buffer(op_e op);
    return (op == OP_PG_ERASE) || (op == OP_BLK_ERASE);
  endfunction

  function automatic logic [7:0] pack_status(logic ready, logic mism);
    return {ready, mism, DENSITY_CODE, 2'b00};
  endfunction

endpackage

// File: rtl/fss_admit.sv
module fss_admit
  import fss_pkg::*;
#(
  parameter int PAGE_W = 9
) (
  input  logic              busy,
  input  op_e               active_op,
  input  logic              launch_valid,
  input  op_e               launch_op,
  input  logic [PAGE_W-1:0] launch_page,
  input  logic              wp_n,
  input  logic              buf_req,
  output logic              launch_go,
  output logic              launch_blocked,
  output logic              buf_go,
  output logic              buf_blocked
);

  function automatic logic in_guarded_half(logic [PAGE_W-1:0] page);
    return page[PAGE_W-1] == 1'b0;
  endfunction

  logic wp_hit;
  logic buf_ok_now;

  always_comb begin
    wp_hit         = !wp_n && op_alters_array(launch_op) && in_guarded_half(launch_page);
    launch_go      = launch_valid && !busy && !wp_hit;
    launch_blocked = launch_valid && !launch_go;
    buf_ok_now     = !busy || op_frees_buffer(active_op);
    buf_go         = buf_req && buf_ok_now;
    buf_blocked    = buf_req && !buf_ok_now;
  end

endmodule

// File: rtl/fss_timer.sv
module fss_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             finishing,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= finishing;
      if (start)
        cnt <= load;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign busy      = (cnt != '0);
  assign finishing = (cnt == CNT_W'(1));

  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/fss_status_shift.sv
module fss_status_shift #(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            shift_en,
  input  logic [SR_W-1:0] status_byte,
  output logic            status_bit
);

  localparam int IDX_W = $clog2(SR_W);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(SR_W - 1);

  logic [IDX_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bit_idx <= TOP;
    else if (cs_n)
      bit_idx <= TOP;
    else if (shift_en)
      bit_idx <= (bit_idx == '0) ? TOP : bit_idx - 1'b1;
  end

  assign status_bit = status_byte[bit_idx];

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> bit_idx == TOP);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && shift_en && bit_idx == '0) |=> bit_idx == TOP);

endmodule

// File: rtl/flash_status_seq.sv
module flash_status_seq
  import fss_pkg::*;
#(
  parameter int PAGE_W          = 9,
  parameter int CYC_XFER        = 12,
  parameter int CYC_PROG        = 40,
  parameter int CYC_ERASE_PROG  = 60,
  parameter int CYC_PAGE_ERASE  = 35,
  parameter int CYC_BLOCK_ERASE = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [2:0]        launch_op,
  input  logic [PAGE_W-1:0] launch_page,
  input  logic              wp_n,
  input  logic              cmp_mismatch,
  input  logic              buf_req,
  input  logic              cs_n,
  input  logic              shift_en,
  output logic              busy_n,
  output logic              op_accept,
  output logic              op_reject,
  output logic              op_done,
  output logic              buf_grant,
  output logic              buf_deny,
  output logic              status_bit
);

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_CYC = max2(max2(max2(CYC_XFER, CYC_PROG), max2(CYC_ERASE_PROG, CYC_PAGE_ERASE)),
                                CYC_BLOCK_ERASE);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  function automatic logic [CNT_W-1:0] op_cycles(op_e op);
    case (op)
      OP_XFER, OP_CMP:                     return CNT_W'(CYC_XFER);
      OP_PROG_NE:                          return CNT_W'(CYC_PROG);
      OP_PG_ERASE:                         return CNT_W'(CYC_PAGE_ERASE);
      OP_BLK_ERASE:                        return CNT_W'(CYC_BLOCK_ERASE);
      default:                             return CNT_W'(CYC_ERASE_PROG);
    endcase
  endfunction

  op_e  req_op;
  op_e  active_op;
  logic cmp_flag;
  logic busy, finishing;
  logic launch_go, launch_blocked, buf_go, buf_blocked;
  logic [7:0] status_byte;

  assign req_op = op_e'(launch_op);

  fss_admit #(.PAGE_W(PAGE_W)) u_admit (
    .busy          (busy),
    .active_op     (active_op),
    .launch_valid  (launch_valid),
    .launch_op     (req_op),
    .launch_page   (launch_page),
    .wp_n          (wp_n),
    .buf_req       (buf_req),
    .launch_go     (launch_go),
    .launch_blocked(launch_blocked),
    .buf_go        (buf_go),
    .buf_blocked   (buf_blocked)
  );

  fss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch_go),
    .load     (op_cycles(req_op)),
    .busy     (busy),
    .finishing(finishing),
    .done     (op_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_op <= OP_XFER;
      cmp_flag  <= 1'b0;
      op_accept <= 1'b0;
      op_reject <= 1'b0;
      buf_grant <= 1'b0;
      buf_deny  <= 1'b0;
    end else begin
      op_accept <= launch_go;
      op_reject <= launch_blocked;
      buf_grant <= buf_go;
      buf_deny  <= buf_blocked;
      if (launch_go)
        active_op <= req_op;
      if (finishing && active_op == OP_CMP)
        cmp_flag <= cmp_mismatch;
    end
  end

  assign busy_n      = !busy;
  assign status_byte = pack_status(!busy, cmp_flag);

  fss_status_shift #(.SR_W(8)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .shift_en   (shift_en),
    .status_byte(status_byte),
    .status_bit (status_bit)
  );

  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |-> !busy_n);

  assert_busy_rejects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && !busy_n) |=> (op_reject && !op_accept));

  assert_buf_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_grant && buf_deny));

  assert_wp_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && !wp_n && launch_op >= 3'd2 && !launch_page[PAGE_W-1]) |=> op_reject);

  assert_flag_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_flag) |-> op_done);

endmodule

// File: tb/flash_status_seq_bench.sv
module flash_status_seq_bench;

  localparam int PAGE_W = 9;
  localparam int D_XFER = 12, D_PROG = 40, D_EP = 60, D_PE = 35, D_BE = 45;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic launch_valid = 1'b0;
  logic [2:0] launch_op = 3'd0;
  logic [PAGE_W-1:0] launch_page = '0;
  logic wp_n = 1'b1, cmp_mismatch = 1'b0, buf_req = 1'b0, cs_n = 1'b1, shift_en = 1'b0;
  logic busy_n, op_accept, op_reject, op_done, buf_grant, buf_deny, status_bit;

  flash_status_seq u_flash_status_seq (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_op(launch_op),
    .launch_page(launch_page), .wp_n(wp_n), .cmp_mismatch(cmp_mismatch), .buf_req(buf_req),
    .cs_n(cs_n), .shift_en(shift_en), .busy_n(busy_n), .op_accept(op_accept),
    .op_reject(op_reject), .op_done(op_done), .buf_grant(buf_grant), .buf_deny(buf_deny),
    .status_bit(status_bit)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  // reference model state
  int m_rem = 0, m_op = 0, m_flag = 0, m_idx = 7;
  int m_acc = 0, m_rej = 0, m_done = 0, m_grant = 0, m_deny = 0;

  function automatic int dur(int op);
    if (op <= 1) return D_XFER;
    if (op == 3) return D_PROG;
    if (op == 4) return D_PE;
    if (op == 5) return D_BE;
    return D_EP;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_rem = 0; m_op = 0; m_flag = 0; m_idx = 7;
      m_acc = 0; m_rej = 0; m_done = 0; m_grant = 0; m_deny = 0;
    end else begin
      int old_rem;
      bit prot;
      old_rem = m_rem;
      m_done = (old_rem == 1);
      if (old_rem == 1 && m_op == 1) m_flag = cmp_mismatch;
      prot = !wp_n && launch_op >= 2 && launch_page < 256;
      m_acc = launch_valid && old_rem == 0 && !prot;
      m_rej = launch_valid && !m_acc;
      m_grant = buf_req && (old_rem == 0 || m_op == 4 || m_op == 5);
      m_deny  = buf_req && !m_grant;
      if (m_acc) begin
        m_rem = dur(launch_op);
        m_op  = launch_op;
      end else if (old_rem > 0) m_rem = old_rem - 1;
      if (cs_n) m_idx = 7;
      else if (shift_en) m_idx = (m_idx + 7) % 8;
    end
  end

  task automatic check(string tag, string nm, logic act, int exp);
    vectors++;
    if (act !== 1'(exp)) begin
      miscompares++;
      $display("FAIL %s %s at cycle %0d: got %b expected %0d", tag, nm, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int sb;
    #5;
    sb = ((m_rem == 0) << 7) | (m_flag << 6) | (3 << 2);
    check("R3", "busy_n", busy_n, m_rem == 0);
    check("R3", "op_accept", op_accept, m_acc);
    check("R4/R6", "op_reject", op_reject, m_rej);
    check("R8", "op_done", op_done, m_done);
    check("R5", "buf_grant", buf_grant, m_grant);
    check("R5", "buf_deny", buf_deny, m_deny);
    check("R1/R2/R7", "status_bit", status_bit, (sb >> m_idx) & 1);
    if (cycles > 60000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(int op, int page);
    @(negedge clk);
    launch_valid = 1'b1; launch_op = 3'(op); launch_page = PAGE_W'(page);
    @(negedge clk);
    launch_valid = 1'b0;
  endtask

  task automatic buf_pulse();
    @(negedge clk); buf_req = 1'b1;
    @(negedge clk); buf_req = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;                       // R9 reset state compared by model
    wait_cyc(2);
    // R2: stream with wrap while idle
    cs_n = 1'b0; shift_en = 1'b1; wait_cyc(20); cs_n = 1'b1; shift_en = 1'b0;
    // R3/R4/R5: transfer, launch and buffer during it
    launch(0, 5); wait_cyc(3); launch(3, 300); buf_pulse(); wait_cyc(12);
    // R5: buffer allowed during page erase; R2 live stream across ready edge
    launch(4, 300); buf_pulse(); cs_n = 1'b0; shift_en = 1'b1; wait_cyc(40);
    cs_n = 1'b1; shift_en = 1'b0;
    // R7: compare mismatch then match
    cmp_mismatch = 1'b1; launch(1, 10); wait_cyc(16);
    cs_n = 1'b0; shift_en = 1'b1; wait_cyc(3); cs_n = 1'b1; wait_cyc(1); cs_n = 1'b0; wait_cyc(10);
    cs_n = 1'b1; shift_en = 1'b0;
    cmp_mismatch = 1'b0; launch(1, 11); wait_cyc(16);
    // R7: other op keeps flag
    cmp_mismatch = 1'b1; launch(0, 12); wait_cyc(16); cmp_mismatch = 1'b0;
    // R6: write protect
    wp_n = 1'b0;
    for (int op = 2; op < 8; op++) begin launch(op, 17); wait_cyc(1); end
    launch(0, 10); wait_cyc(14); launch(1, 200); wait_cyc(14);
    launch(6, 400); wait_cyc(62); launch(7, 256); wait_cyc(62);
    launch(5, 511); buf_pulse(); wait_cyc(46);
    wp_n = 1'b1;
    launch(2, 10); buf_pulse(); wait_cyc(62);
    launch(3, 0); wait_cyc(42); launch(5, 16); buf_pulse(); wait_cyc(46);
    launch(6, 1); wait_cyc(62); launch(7, 0); wait_cyc(62);
    // R9: abort mid-operation with flag set
    cmp_mismatch = 1'b1; launch(1, 3); wait_cyc(16); cmp_mismatch = 1'b0;
    launch(2, 300); cs_n = 1'b0; shift_en = 1'b1; wait_cyc(10);
    rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1; wait_cyc(3);
    cs_n = 1'b1; shift_en = 1'b0;
    launch(0, 1); wait_cyc(16);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule